// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of every beat of one SDRAM read or write burst. A controller first programs a mode word, carried on the address pins during a mode-register-set cycle. That word holds a burst-length code and an ordering bit. The controller then pulses a start strobe together with the first column. From the edge that takes the start, the block puts out one column address per clock, with no gap between beats. It raises a last-beat flag on the final beat of a fixed burst.

Fixed bursts of 1, 2, 4 or 8 beats step through the aligned block that contains the start column. The ordering is either sequential, where the address wraps inside the block, or interleaved, where the beat number is XORed into the low bits. A full-page burst walks the whole 1024-column row, wrapping modulo 1024. It runs until a burst-stop strobe ends it. The stop strobe also cuts any fixed burst short. The mode fields are copied into the burst when it starts. A new mode word is accepted only while no burst is in progress.

Top module: `col_burst_gen`

## Requirements
- R1: During reset and after it, col_valid and col_last are 0 and col_addr is 0. The stored mode is length code 000 (one beat) with sequential ordering.
- R2: A start strobe sampled at a clock edge makes col_valid 1 after that edge, with col_addr equal to the sampled start_col. Start has priority over stop and over the current burst.
- R3: Length codes in mode_word[2:0] are 000=1, 001=2, 010=4 and 011=8 beats. A fixed burst shows exactly that many valid beats on consecutive cycles. col_last is 1 only on the final beat, and col_valid falls on the following cycle.
- R4: With mode_word[3]=0 (sequential), beat n of a length-L burst from column S is (S with its low log2(L) bits cleared) plus ((S+n) mod L).
- R5: With mode_word[3]=1 (interleaved), beat n of a fixed length-L burst is S XOR n.
- R6: Length code 111 (full page) gives beat n = (S+n) mod 1024. col_last is never raised and the burst never ends by itself.
- R7: A stop strobe sampled without start during a burst drops col_valid after that edge, for any length.
- R8: A mode word loaded while col_valid is 1 is ignored. A burst started at the same edge as a mode load still uses the previously stored mode.
- R9: A start during a burst restarts at the new column on the very next cycle, with no idle cycle.
- R10: The unused length codes 100, 101 and 110 act as a one-beat burst.
- R11: In full-page mode the ordering bit has no effect, and stepping is always sequential.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Mode-register-set strobe |
| mode_word | input | 12 | Mode word; [2:0] length code, [3] ordering |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 10 | First column of the burst |
| stop | input | 1 | Burst-stop strobe |
| col_addr | output | 10 | Column address of the current beat |
| col_valid | output | 1 | A burst beat is being presented |
| col_last | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The assertions assume that strobes are sampled only on rising edges and that start, stop and mode_load are plain single-cycle pulses. They also assume that a stop arriving while idle is harmless. The stimulus drives every input on the falling edge and holds it for a full cycle. It issues mode loads both while idle and during bursts, and it also places start and stop on the same edge. This covers each priority case the assertions rely on while staying within these input rules.

// File: rtl/col_burst_pkg.sv
// Package: shared widths, field positions and mode decoding helpers for
// the burst column address generator. Assumes a power-of-two row length.
package col_burst_pkg;

    localparam int COL_W      = 10;
    localparam int LEN_CODE_W = 3;
    localparam int ORD_BIT    = 3;

    // Length code carried in the low bits of the mode word.
    typedef enum logic [LEN_CODE_W-1:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    // Decoded burst shape latched for the duration of a burst.
    typedef struct packed {
        logic [COL_W-1:0] mask;   // low-bit mask, length minus one
        logic             page;   // unbounded full-page burst
        logic             ilv;    // interleaved ordering in effect
    } burst_shape_t;

    // Map a length code to its low-bit mask; unknown codes give one beat.
    function automatic logic [COL_W-1:0] code_to_mask(input logic [LEN_CODE_W-1:0] code);
        logic [COL_W-1:0] m;
        case (code)
            LEN_TWO:   m = COL_W'(1);
            LEN_FOUR:  m = COL_W'(3);
            LEN_EIGHT: m = COL_W'(7);
            LEN_PAGE:  m = '1;
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/col_mode_reg.sv
// Mode register: stores the length code and ordering bit from a mode word.
// Assumes loads are legal only while no burst runs; others are dropped.
// Produces the decoded burst shape that the sequencer copies at start.
module col_mode_reg
    import col_burst_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               busy,
    input  logic [MODE_W-1:0]  word,
    output burst_shape_t       shape
);

    logic [LEN_CODE_W-1:0] code_q;
    logic                  ilv_q;
    logic                  page_dec;

    // Capture the mode fields on an accepted load; reset to one-beat sequential.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= LEN_ONE;
            ilv_q  <= 1'b0;
        end else if (load && !busy) begin
            code_q <= word[LEN_CODE_W-1:0];
            ilv_q  <= word[ORD_BIT];
        end
    end

    // Decode the stored fields into mask, page flag and effective ordering.
    always_comb begin
        page_dec   = (code_q == LEN_PAGE);
        shape.mask = code_to_mask(code_q);
        shape.page = page_dec;
        shape.ilv  = ilv_q && !page_dec;
    end

endmodule

// File: rtl/col_burst_seq.sv
// Burst sequencer: tracks whether a burst runs, its start column and the
// current beat number. Start beats stop, stop beats natural advance.
// Assumes the shape input is stable except when mode loads are accepted.
module col_burst_seq
    import col_burst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    input  logic [COL_W-1:0]   start_col,
    input  burst_shape_t       shape_in,
    output logic               busy,
    output logic               last,
    output logic [COL_W-1:0]   base,
    output logic [COL_W-1:0]   beat,
    output burst_shape_t       shape_q
);

    logic             busy_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic             last_now;

    // Final beat of a fixed burst: beat count has reached length minus one.
    always_comb begin
        last_now = busy_q && !shape_q.page && (beat_q == shape_q.mask);
    end

    // Advance, restart or end the burst on each clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            base_q  <= '0;
            beat_q  <= '0;
            shape_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            base_q  <= start_col;
            beat_q  <= '0;
            shape_q <= shape_in;
        end else if (busy_q) begin
            if (stop || last_now) begin
                busy_q <= 1'b0;
            end else begin
                beat_q <= beat_q + COL_W'(1);
            end
        end
    end

    assign busy = busy_q;
    assign last = last_now;
    assign base = base_q;
    assign beat = beat_q;

endmodule

// File: rtl/col_addr_step.sv
// Address stepper: forms the column of the current beat from the start
// column and beat number. Bits outside the mask keep the start column;
// masked bits take either the wrapped sum or the XOR of the beat number.
module col_addr_step
    import col_burst_pkg::*;
(
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  burst_shape_t     shape,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] sum;

    // Wrapped sequential sum; carries beyond the mask are discarded per bit.
    always_comb begin
        sum = base + beat;
    end

    // Per-bit select between fixed upper bits, sequential and interleaved.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!shape.mask[i]) begin
                addr[i] = base[i];
            end else if (shape.ilv) begin
                addr[i] = base[i] ^ beat[i];
            end else begin
                addr[i] = sum[i];
            end
        end
    end

endmodule

// File: rtl/col_burst_gen.sv
// Top: SDRAM burst column address generator. Holds the programmed mode,
// sequences one burst at a time and presents one column per clock.
// Assumes synchronous active-low reset and single-cycle strobes.
module col_burst_gen
    import col_burst_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_load,
    input  logic [MODE_W-1:0]  mode_word,
    input  logic               start,
    input  logic [COL_W-1:0]   start_col,
    input  logic               stop,
    output logic [COL_W-1:0]   col_addr,
    output logic               col_valid,
    output logic               col_last
);

    burst_shape_t     shape_mode;
    burst_shape_t     shape_run;
    logic             busy;
    logic             last;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;

    col_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .busy  (busy),
        .word  (mode_word),
        .shape (shape_mode)
    );

    col_burst_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .shape_in  (shape_mode),
        .busy      (busy),
        .last      (last),
        .base      (base),
        .beat      (beat),
        .shape_q   (shape_run)
    );

    col_addr_step u_step (
        .base  (base),
        .beat  (beat),
        .shape (shape_run),
        .addr  (col_addr)
    );

    assign col_valid = busy;
    assign col_last  = last;

endmodule

// File: rtl/col_burst_gen_chk.sv
// Checker for the burst column address generator, bound to the top.
module col_burst_gen_chk
    import col_burst_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_last
);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_addr == $past(start_col)));

    assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_valid);

    assert_last_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !stop) |=> col_valid);

    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && stop && !start) |=> !col_valid);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_valid && !start) |=> !col_valid);

endmodule

bind col_burst_gen col_burst_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .stop      (stop),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .col_last  (col_last)
);

// File: tb/col_burst_gen_tb.sv
`timescale 1ns/1ps
module col_burst_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [11:0] mode_word = '0;
    logic       start = 1'b0;
    logic [9:0] start_col = '0;
    logic       stop = 1'b0;
    logic [9:0] col_addr;
    logic       col_valid;
    logic       col_last;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_busy = 0, m_base = 0, m_n = 0, m_len = 1, m_page = 0, m_ilv = 0;
    int r_code = 0, r_ilv = 0;

    always #2.5 clk = ~clk;

    col_burst_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .stop(stop),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last)
    );

    function automatic int len_of(input int code);
        if (code == 7) return 1024;
        if (code <= 3) return 1 << code;
        return 1;
    endfunction

    function automatic int exp_addr();
        if (m_page) return (m_base + m_n) % 1024;
        if (m_ilv) return m_base ^ m_n;
        return (m_base - (m_base % m_len)) + ((m_base + m_n) % m_len);
    endfunction

    function automatic int exp_last();
        return (m_busy && !m_page && m_n == m_len - 1) ? 1 : 0;
    endfunction

    task automatic check(input string tag, input int act, input int expv, input string what);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    // One clock: update model at the edge, compare at the falling edge.
    task automatic tick(input string tag);
        int old_busy;
        @(posedge clk);
        old_busy = m_busy;
        if (!rst_n) begin
            m_busy = 0; m_base = 0; m_n = 0; r_code = 0; r_ilv = 0;
            m_len = 1; m_page = 0; m_ilv = 0;
        end else begin
            if (start) begin
                m_busy = 1; m_base = start_col; m_n = 0;
                m_len = len_of(r_code); m_page = (r_code == 7);
                m_ilv = m_page ? 0 : r_ilv;
            end else if (m_busy) begin
                if (stop || exp_last()) m_busy = 0;
                else m_n = m_n + 1;
            end
            if (mode_load && !old_busy) begin
                r_code = mode_word[2:0]; r_ilv = mode_word[3];
            end
        end
        @(negedge clk);
        check(tag, col_valid, m_busy, "valid");
        check(tag, col_last, m_busy ? exp_last() : 0, "last");
        if (m_busy) check(tag, col_addr, exp_addr(), "addr");
    endtask

    task automatic load_mode(input int code, input int ilv, input string tag);
        mode_word = 12'(code | (ilv << 3)); mode_load = 1'b1;
        tick(tag);
        mode_load = 1'b0;
    endtask

    task automatic begin_burst(input int col, input string tag);
        start_col = 10'(col); start = 1'b1;
        tick(tag);
        start = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(2, "R1");
        check("R1", col_addr, 0, "reset addr");
        rst_n = 1'b1;
        idle(2, "R1");
        check("R1", col_addr, 0, "addr after reset");
        // default mode: one beat, sequential
        begin_burst(10'h155, "R1");
        idle(2, "R1");

        // every fixed length, both orderings, unaligned start
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int code = 0; code < 4; code++) begin
                load_mode(code, ilv, "R3");
                begin_burst(10'h3F5, ilv ? "R5" : "R4");
                idle(len_of(code) + 1, ilv ? "R5" : "R4");
                begin_burst(10'h0C2, "R3");
                idle(len_of(code) + 1, "R3");
            end
        end

        // reserved codes give one beat
        for (int code = 4; code < 7; code++) begin
            load_mode(code, 0, "R10");
            begin_burst(10'h2A7, "R10");
            idle(2, "R10");
        end

        // full page wraps through 1023 and runs long, then stops
        load_mode(7, 0, "R6");
        begin_burst(1020, "R6");
        idle(1100, "R6");
        stop = 1'b1; tick("R7"); stop = 1'b0;
        idle(2, "R7");

        // full page with ordering bit set still increments
        load_mode(7, 1, "R11");
        begin_burst(10'h13D, "R11");
        idle(12, "R11");
        stop = 1'b1; tick("R11"); stop = 1'b0;
        idle(1, "R11");

        // stop cuts a fixed burst short
        load_mode(3, 0, "R7");
        begin_burst(10'h011, "R7");
        idle(2, "R7");
        stop = 1'b1; tick("R7"); stop = 1'b0;
        idle(2, "R7");

        // start and stop together: start wins
        begin_burst(10'h200, "R2");
        start_col = 10'h0F3; start = 1'b1; stop = 1'b1;
        tick("R2");
        start = 1'b0; stop = 1'b0;
        idle(9, "R2");

        // mode load during a burst is ignored
        begin_burst(10'h044, "R8");
        load_mode(1, 1, "R8");
        idle(8, "R8");
        begin_burst(10'h045, "R8");
        idle(9, "R8");

        // mode load at the same edge as start: burst uses old mode (8 seq)
        mode_word = 12'h009; mode_load = 1'b1;
        start_col = 10'h3FE; start = 1'b1;
        tick("R8");
        mode_load = 1'b0; start = 1'b0;
        idle(9, "R8");
        begin_burst(10'h3FE, "R8");
        idle(3, "R8");

        // back-to-back restarts with no gap
        load_mode(2, 0, "R9");
        begin_burst(10'h101, "R9");
        begin_burst(10'h2F2, "R9");
        tick("R9");
        begin_burst(10'h007, "R9");
        idle(6, "R9");

        // stop while idle does nothing
        stop = 1'b1; tick("R7"); stop = 1'b0;
        idle(1, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule